// File: doc/BRIEF.md
# Configurable Registered Buffer with Delayed Parity Check

This block is a single clocked register stage for the address and command lines of a memory interface. It takes a 25-lane data word plus clock-enable, on-die-termination and chip-select controls. On every rising clock edge it captures them and presents them on registered outputs.

A two-bit configuration input sets the register shape. In wide mode, one copy of each live lane is driven. In the two narrow modes, a smaller set of lanes is live and every live lane is driven on two identical output copies. When both chip-select inputs are high, the data outputs are frozen. The control outputs follow their inputs on every edge regardless of chip select.

The parity bit for a data word arrives one clock after that word. The block keeps the odd parity of the live lanes it captured and shows it on a partial-parity output. On the next edge it combines that stored parity with the late parity bit. It then drives an active-low error flag, which appears one cycle after the data it refers to.

The parity checker is a two-state machine:
- WAIT_WORD is the state after reset. The error flag is held high there.
- The FIRST_CAPTURE transition moves it to CHECKING on the first edge after reset.
- CHECKING stays in place through the STAY_CHECKING transition until the next reset.

Top module: `regbuf_par`

## Requirements
- R1: While `rst_n` is low, all registered outputs are 0 and `err_n` is 1. Reset acts at once, without waiting for a clock edge.
- R2: With `cfg`=2'b00 (wide, one copy), `q_a` bit k-1 takes `din` bit k-1 on each loading edge for lanes k = 2, 3, 5, 6 and 8 through 25. `q_b` stays 0.
- R3: With `cfg`=2'b10 (narrow, two copies), lanes 2, 3, 5, 6 and 8 through 14 are live. `q_a` and `q_b` both carry them.
- R4: With `cfg`=2'b11 (alternate narrow, two copies), lanes 1 through 6, 8, 9, 10, 12 and 13 are live. `q_a` and `q_b` both carry them.
- R5: With `cfg`=2'b01 (reserved), no lane is live. `q_a`, `q_b` and `ppo` stay 0.
- R6: A lane that is not live in the current configuration reads 0 on both copies. It has no effect on `ppo` or on `err_n`.
- R7: An edge at which `cs_n`=2'b11 leaves `q_a` and `q_b` unchanged. Any other `cs_n` value loads them.
- R8: On every edge, `cke_q_a`/`cke_q_b` take `cke_in`, `odt_q_a`/`odt_q_b` take `odt_in`, and `cs_q_a`/`cs_q_b` take `cs_n[0]`. This happens whatever the chip-select state.
- R9: After each edge, `ppo` equals the XOR of the live lanes of the `din` word captured at that edge. This holds even when the data outputs were frozen.
- R10: `par_in` sampled at edge k+1 belongs to the word captured at edge k. After edge k+1, `err_n` is 0 exactly when that word's live-lane XOR, XORed with `par_in`, is 0.
- R11: The first edge after reset does not change `err_n`. It stays 1 until a word and its parity have both been taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg | input | 2 | Register shape select (see R2 to R5) |
| cs_n | input | 2 | Chip selects, active low; both high freezes data |
| din | input | 25 | Data lanes; bit k-1 is lane k |
| cke_in | input | 1 | Clock-enable input |
| odt_in | input | 1 | Termination-control input |
| par_in | input | 1 | Parity of the word captured one edge earlier |
| q_a | output | 25 | Primary registered data copy |
| q_b | output | 25 | Second data copy in the narrow modes, 0 in wide mode |
| cs_q_a | output | 1 | Registered `cs_n[0]`, copy A |
| cs_q_b | output | 1 | Registered `cs_n[0]`, copy B |
| cke_q_a | output | 1 | Registered clock enable, copy A |
| cke_q_b | output | 1 | Registered clock enable, copy B |
| odt_q_a | output | 1 | Registered termination control, copy A |
| odt_q_b | output | 1 | Registered termination control, copy B |
| ppo | output | 1 | Odd parity of the live lanes last captured |
| err_n | output | 1 | Active-low parity error, one cycle after the data |

## Verification
The lane and copy assertions assume `cfg` is static while out of reset. A change would remap the live lanes under data already held in the registers. The bench therefore changes `cfg` only while `rst_n` is low and runs each mode from a fresh reset. It drives every input on the falling edge and keeps sending a word on every cycle after reset is released. This keeps the late parity bit paired with a known earlier word, and the first-pair rule is exercised on a defined edge.

// File: rtl/regbuf_pkg.sv
package regbuf_pkg;

    // bit 0 and bit 1 of the shape select
    typedef enum logic [1:0] {
        CFG_WIDE   = 2'b00,
        CFG_RSVD   = 2'b01,
        CFG_NARROW = 2'b10,
        CFG_ALT    = 2'b11
    } cfg_e;

    typedef enum logic {
        WAIT_WORD = 1'b0,
        CHECKING  = 1'b1
    } pstate_e;

    // lane numbers count from 1
    function automatic logic lane_live(cfg_e m, int lane);
        logic r;
        r = 1'b0;
        case (m)
            CFG_WIDE:   r = (lane inside {2, 3, 5, 6}) || (lane >= 8 && lane <= 25);
            CFG_NARROW: r = (lane inside {2, 3, 5, 6}) || (lane >= 8 && lane <= 14);
            CFG_ALT:    r = (lane >= 1 && lane <= 6) || (lane inside {8, 9, 10, 12, 13});
            default:    r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/regbuf_lane_map.sv
module regbuf_lane_map
    import regbuf_pkg::*;
#(
    parameter int W = 25
) (
    input  logic [1:0]   cfg,
    output logic [W-1:0] mask,
    output logic         dup
);
    cfg_e mode;
    assign mode = cfg_e'(cfg);

    for (genvar i = 0; i < W; i++) begin : g_lane
        assign mask[i] = lane_live(mode, i + 1);
    end

    assign dup = (mode == CFG_NARROW) || (mode == CFG_ALT);
endmodule

// File: rtl/regbuf_data_stage.sv
module regbuf_data_stage #(
    parameter int W = 25
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         dup,
    input  logic [W-1:0] mask,
    input  logic [W-1:0] din,
    output logic [W-1:0] q_a,
    output logic [W-1:0] q_b
);
    logic [W-1:0] live;
    assign live = din & mask;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_a <= '0;
            q_b <= '0;
        end else if (load) begin
            q_a <= live;
            q_b <= dup ? live : '0;
        end
    end

    // R7
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ($stable(q_a) && $stable(q_b)));

    // R6
    inactive_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((q_a | q_b) & ~mask) == '0);

    // R3
    copy_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dup |-> (q_b == q_a));

    // R2
    single_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dup |-> (q_b == '0));
endmodule

// File: rtl/regbuf_parity_chk.sv
module regbuf_parity_chk
    import regbuf_pkg::*;
#(
    parameter int W = 25
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    input  logic [W-1:0] mask,
    input  logic         par_in,
    output logic         ppo,
    output logic         err_n
);
    pstate_e state, state_nxt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= WAIT_WORD;
        else        state <= state_nxt;
    end

    always_comb begin
        unique case (state)
            WAIT_WORD: state_nxt = CHECKING;   // FIRST_CAPTURE
            CHECKING:  state_nxt = CHECKING;   // STAY_CHECKING
            default:   state_nxt = WAIT_WORD;
        endcase
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ppo   <= 1'b0;
            err_n <= 1'b1;
        end else begin
            ppo <= ^(din & mask);
            unique case (state)
                WAIT_WORD: err_n <= 1'b1;
                CHECKING:  err_n <= ppo ^ par_in;
                default:   err_n <= 1'b1;
            endcase
        end
    end

    // R11
    err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == WAIT_WORD) |-> err_n);

    // R5
    empty_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |=> !ppo);
endmodule

// File: rtl/regbuf_par.sv
module regbuf_par #(
    parameter int W = 25
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [1:0]   cfg,
    input  logic [1:0]   cs_n,
    input  logic [W-1:0] din,
    input  logic         cke_in,
    input  logic         odt_in,
    input  logic         par_in,
    output logic [W-1:0] q_a,
    output logic [W-1:0] q_b,
    output logic         cs_q_a,
    output logic         cs_q_b,
    output logic         cke_q_a,
    output logic         cke_q_b,
    output logic         odt_q_a,
    output logic         odt_q_b,
    output logic         ppo,
    output logic         err_n
);
    logic [W-1:0] mask;
    logic         dup;
    logic         load;
    logic         cs_r, cke_r, odt_r;

    assign load = ~(&cs_n);

    regbuf_lane_map #(.W(W)) u_map (
        .cfg  (cfg),
        .mask (mask),
        .dup  (dup)
    );

    regbuf_data_stage #(.W(W)) u_data (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .dup   (dup),
        .mask  (mask),
        .din   (din),
        .q_a   (q_a),
        .q_b   (q_b)
    );

    regbuf_parity_chk #(.W(W)) u_par (
        .clk    (clk),
        .rst_n  (rst_n),
        .din    (din),
        .mask   (mask),
        .par_in (par_in),
        .ppo    (ppo),
        .err_n  (err_n)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_r  <= 1'b0;
            cke_r <= 1'b0;
            odt_r <= 1'b0;
        end else begin
            cs_r  <= cs_n[0];
            cke_r <= cke_in;
            odt_r <= odt_in;
        end
    end

    assign cs_q_a  = cs_r;
    assign cs_q_b  = cs_r;
    assign cke_q_a = cke_r;
    assign cke_q_b = cke_r;
    assign odt_q_a = odt_r;
    assign odt_q_b = odt_r;

    // R8
    ctrl_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (&cs_n) |=> ((cke_q_a == $past(cke_in)) && (odt_q_b == $past(odt_in))));
endmodule

// File: tb/regbuf_par_bench.sv
module regbuf_par_bench;
    localparam int W = 25;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic         rst_n = 1'b0;
    logic [1:0]   cfg = 2'b00;
    logic [1:0]   cs_n = 2'b00;
    logic [W-1:0] din = '0;
    logic         cke_in = 1'b0, odt_in = 1'b0, par_in = 1'b0;
    logic [W-1:0] q_a, q_b;
    logic         cs_q_a, cs_q_b, cke_q_a, cke_q_b, odt_q_a, odt_q_b, ppo, err_n;

    regbuf_par #(.W(W)) u_regbuf_par (
        .clk(clk), .rst_n(rst_n), .cfg(cfg), .cs_n(cs_n), .din(din),
        .cke_in(cke_in), .odt_in(odt_in), .par_in(par_in),
        .q_a(q_a), .q_b(q_b), .cs_q_a(cs_q_a), .cs_q_b(cs_q_b),
        .cke_q_a(cke_q_a), .cke_q_b(cke_q_b), .odt_q_a(odt_q_a), .odt_q_b(odt_q_b),
        .ppo(ppo), .err_n(err_n)
    );

    typedef struct packed {
        logic [W-1:0] qa;
        logic [W-1:0] qb;
        logic [5:0]   ctl;
        logic         ppo;
        logic         err;
    } exp_t;

    exp_t  sb[$];
    string dtag_q[$];
    string etag_q[$];

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [W-1:0] m_qa, m_qb;
    logic         m_prev, m_err;
    bit           m_have;

    function automatic logic [W-1:0] bmask(logic [1:0] c);
        logic [W-1:0] m;
        m = '0;
        for (int lane = 1; lane <= W; lane++) begin
            case (c)
                2'b00: m[lane-1] = (lane == 2 || lane == 3 || lane == 5 || lane == 6 || lane >= 8);
                2'b10: m[lane-1] = (lane == 2 || lane == 3 || lane == 5 || lane == 6 ||
                                    (lane >= 8 && lane <= 14));
                2'b11: m[lane-1] = (lane <= 6 || lane == 8 || lane == 9 || lane == 10 ||
                                    lane == 12 || lane == 13);
                default: m[lane-1] = 1'b0;
            endcase
        end
        return m;
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // called at a falling edge; leaves at the next falling edge
    task automatic apply(input logic [W-1:0] d, input logic [1:0] cs, input logic cke,
                         input logic odt, input logic par, input string tag);
        exp_t e;
        logic [W-1:0] live;
        logic wp;
        din = d; cs_n = cs; cke_in = cke; odt_in = odt; par_in = par;
        live = d & bmask(cfg);
        wp = ^live;
        if (cs != 2'b11) begin
            m_qa = live;
            m_qb = cfg[1] ? live : '0;
        end
        etag_q.push_back(m_have ? "R10" : "R11");
        if (m_have) m_err = m_prev ^ par;
        m_have = 1'b1;
        m_prev = wp;
        e.qa = m_qa; e.qb = m_qb;
        e.ctl = {cs[0], cs[0], cke, cke, odt, odt};
        e.ppo = wp; e.err = m_err;
        sb.push_back(e);
        dtag_q.push_back(tag);
        @(negedge clk);
    endtask

    task automatic do_reset(input logic [1:0] c);
        rst_n = 1'b0;
        cfg = c;
        #1;
        chk(q_a == '0 && q_b == '0, "R1", "reset data", q_a | q_b, '0);
        chk({cs_q_a, cs_q_b, cke_q_a, cke_q_b, odt_q_a, odt_q_b, ppo} == '0, "R1", "reset ctl",
            W'({cs_q_a, cs_q_b, cke_q_a, cke_q_b, odt_q_a, odt_q_b, ppo}), '0);
        chk(err_n == 1'b1, "R1", "reset err_n", W'(err_n), W'(1));
        m_qa = '0; m_qb = '0; m_prev = 1'b0; m_err = 1'b1; m_have = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // monitor: compares one scoreboard item per clock
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) begin
                exp_t e;
                string dt, et;
                e  = sb.pop_front();
                dt = dtag_q.pop_front();
                et = etag_q.pop_front();
                chk(q_a == e.qa, dt, "q_a", q_a, e.qa);
                chk(q_b == e.qb, dt, "q_b", q_b, e.qb);
                chk({cs_q_a, cs_q_b, cke_q_a, cke_q_b, odt_q_a, odt_q_b} == e.ctl, "R8", "ctl",
                    W'({cs_q_a, cs_q_b, cke_q_a, cke_q_b, odt_q_a, odt_q_b}), W'(e.ctl));
                chk(ppo == e.ppo, "R9", "ppo", W'(ppo), W'(e.ppo));
                chk(err_n == e.err, et, "err_n", W'(err_n), W'(e.err));
            end
        end
    end

    task automatic run_mode(input logic [1:0] c, input string tag);
        do_reset(c);
        // first pair: parity that would flag if it were checked (R11)
        apply(W'($urandom), 2'b00, 1'b1, 1'b0, 1'b0, "R11");
        for (int i = 0; i < 24; i++) begin
            logic [1:0] cs;
            logic flip;
            cs   = (i % 6 == 5) ? 2'b11 : 2'(i % 3);
            flip = (i % 4 == 3);
            apply(W'($urandom), cs, 1'($urandom), 1'($urandom), ~m_prev ^ flip,
                  (cs == 2'b11) ? "R7" : tag);
        end
        // R6: every lane driven high, unused lanes must stay quiet
        apply({W{1'b1}}, 2'b10, 1'b0, 1'b1, ~m_prev, "R6");
        // R7: frozen output while ppo and control keep moving (R9, R8)
        apply('0, 2'b11, 1'b1, 1'b0, 1'b0, "R7");
        apply(W'($urandom), 2'b01, 1'b0, 1'b0, ~m_prev, tag);
    endtask

    initial begin
        @(negedge clk);
        run_mode(2'b00, "R2");
        run_mode(2'b10, "R3");
        run_mode(2'b11, "R4");
        run_mode(2'b01, "R5");
        do_reset(2'b00);
        @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog all requirements actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule